// File: doc/BRIEF.md
# Register stack frame renamer

This block turns the virtual general-register numbers named by instructions into indices of a circular physical file of stacked registers. Numbers below 32 are global and pass through unchanged. From 32 upward each procedure sees its own window, which starts at a physical base and covers a frame of 0 to 96 registers. Three independent lookup ports are resolved combinationally every cycle. Each port reports the physical index, whether the number was global, and whether it lies beyond the current frame.

Three strobes move the window. A call slides the base past the caller's locals, so the caller's outputs become the callee's first registers. An allocate resizes the current frame from a local count, an output count and a rotating count. A return pops a saved frame marker and restores the caller's frame exactly. The physical file also keeps registers that belong to suspended callers. When a resize would push that total past the file size, the oldest of those registers are written out to a backing store, one per handshake. When a return finds that some of the caller's locals were written out, they are read back first. While either transfer is running, the block reports busy and ignores all three strobes.

Top module: `regstack_renamer`

## Requirements
- R1: A virtual number below 32 gives glob=1, oof=0 and a physical index equal to the number.
- R2: A virtual number v of 32 or more maps to (base + v - 32) mod PHYS. When v >= 32 + frame size, oof=1. After reset the frame is empty (size 0) and the base is 0.
- R3: An allocate with loc+out <= 96 and rot <= loc+out sets frame size = loc+out and local count = loc. Any other allocate leaves the frame unchanged and sets the error flag.
- R4: A call moves the base up by the local count, sets frame size = size - locals and local count = 0. Virtual 32 then names the caller's first output.
- R5: A return restores base, size and local count to the values saved by the matching call. A return with no saved marker sets the error flag and changes nothing.
- R6: The marker stack holds 16 entries. A call made while 16 markers are saved sets the error flag and is ignored.
- R7: Suppose an accepted allocate makes retained-caller registers + new frame size exceed PHYS. The excess is then written out, oldest first (mem_we=1). The physical indices rise from the oldest retained register, and the addresses rise from the backing-store pointer, which is 0 after reset.
- R8: Suppose a return needs caller locals that were written out. They are read back (mem_we=0) highest physical index first, at descending addresses that end where the matching spills began.
- R9: busy is high while transfers remain, and call/allocate/return strobes seen while busy have no effect. A request not accepted (mem_ready low) keeps its index, address and direction.
- R10: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vreg_i | input | 21 | Three 7-bit virtual register numbers, port k at bits [7k+6:7k] |
| phys_o | output | 3*PW | Three physical indices, port k at [PW*k +: PW] |
| glob_o | output | 3 | Per port: number is global |
| oof_o | output | 3 | Per port: stacked number outside the current frame |
| call_i | input | 1 | Call strobe |
| alloc_i | input | 1 | Allocate strobe |
| alloc_loc_i | input | 7 | Allocate local count |
| alloc_out_i | input | 7 | Allocate output count |
| alloc_rot_i | input | 7 | Allocate rotating count |
| ret_i | input | 1 | Return strobe |
| busy_o | output | 1 | Spill or fill in progress |
| err_o | output | 1 | Sticky error flag |
| mem_valid_o | output | 1 | Backing-store request valid |
| mem_we_o | output | 1 | 1 = spill (write), 0 = fill (read) |
| mem_addr_o | output | AW | Backing-store register slot |
| mem_phys_o | output | PW | Physical register moved by the request |
| mem_ready_i | input | 1 | Backing store accepts the request |

## Verification
The assertions check the following on every cycle: the frame never exceeds 96 registers, the retained total never exceeds the file size once transfers are done, a stalled request holds steady, strobes during busy leave the frame alone, a call clears the local count, and the error flag never drops. Only the bench scenarios can show the frame arithmetic itself. That covers the nested call, allocate and return chain with its exact indices, the wrap of an index past the end of the file, the order and addresses of spills and of the fills that mirror them, and the rejection of bad allocates, full-stack calls and empty-stack returns.

// File: rtl/regstack_renamer.sv
module regstack_renamer #(
  parameter int PHYS   = 128,
  parameter int MDEPTH = 16,
  parameter int AW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [20:0]       vreg_i,
  output logic [3*$clog2(PHYS)-1:0] phys_o,
  output logic [2:0]        glob_o,
  output logic [2:0]        oof_o,
  input  logic              call_i,
  input  logic              alloc_i,
  input  logic [6:0]        alloc_loc_i,
  input  logic [6:0]        alloc_out_i,
  input  logic [6:0]        alloc_rot_i,
  input  logic              ret_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [$clog2(PHYS)-1:0] mem_phys_o,
  input  logic              mem_ready_i
);
  localparam int VW   = 7;
  localparam int PW   = $clog2(PHYS);
  localparam int CW   = PW + 1;
  localparam int TW   = $clog2(MDEPTH);
  localparam logic [PW:0] PHYS_W = (PW+1)'(PHYS);
  localparam logic [CW:0] PHYS_C = (CW+1)'(PHYS);
  localparam logic [7:0]  MAXF   = 8'd96;

  logic [PW-1:0] bof;
  logic [6:0]    sof, sol;
  logic [CW-1:0] ndirty, spill_left;
  logic [6:0]    fill_left;
  logic [AW-1:0] bsp;
  logic [TW:0]   sp;
  logic          err;

  logic [PW-1:0] mk_bof [MDEPTH];
  logic [6:0]    mk_sof [MDEPTH];
  logic [6:0]    mk_sol [MDEPTH];

  function automatic logic [PW-1:0] wrap(input logic [PW:0] a);
    logic [PW:0] t;
    t = (a >= PHYS_W) ? a - PHYS_W : a;
    return t[PW-1:0];
  endfunction

  logic busy, spilling, xfer;
  assign spilling = |spill_left;
  assign busy     = spilling || (|fill_left);
  assign xfer     = busy && mem_ready_i;

  logic do_call, do_alloc, do_ret;
  assign do_call  = !busy && call_i;
  assign do_alloc = !busy && !call_i && alloc_i;
  assign do_ret   = !busy && !call_i && !alloc_i && ret_i;

  logic [7:0]    asum;
  logic          alloc_ok;
  logic [CW:0]   need;
  logic [CW-1:0] spill_need;
  assign asum       = {1'b0, alloc_loc_i} + {1'b0, alloc_out_i};
  assign alloc_ok   = (asum <= MAXF) && ({1'b0, alloc_rot_i} <= asum);
  assign need       = (CW+1)'(ndirty) + (CW+1)'(asum);
  assign spill_need = (need > PHYS_C) ? CW'(need - PHYS_C) : '0;

  logic          push_ok, pop_ok;
  logic [TW-1:0] top;
  logic [6:0]    t_sol;
  logic          t_short;
  assign push_ok = sp < (TW+1)'(MDEPTH);
  assign pop_ok  = sp != '0;
  assign top     = TW'(sp - 1'b1);
  assign t_sol   = mk_sol[top];
  assign t_short = ndirty < CW'(t_sol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bof <= '0; sof <= '0; sol <= '0;
      ndirty <= '0; spill_left <= '0; fill_left <= '0;
      bsp <= '0; sp <= '0; err <= 1'b0;
    end else begin
      if (xfer) begin
        if (spilling) begin
          spill_left <= spill_left - 1'b1;
          ndirty     <= ndirty - 1'b1;
          bsp        <= bsp + 1'b1;
        end else begin
          fill_left  <= fill_left - 1'b1;
          bsp        <= bsp - 1'b1;
        end
      end
      if (do_call) begin
        if (push_ok) begin
          bof    <= wrap({1'b0, bof} + (PW+1)'(sol));
          sof    <= sof - sol;
          sol    <= '0;
          ndirty <= ndirty + CW'(sol);
          sp     <= sp + 1'b1;
        end else err <= 1'b1;
      end
      if (do_alloc) begin
        if (alloc_ok) begin
          sof        <= asum[6:0];
          sol        <= alloc_loc_i;
          spill_left <= spill_need;
        end else err <= 1'b1;
      end
      if (do_ret) begin
        if (pop_ok) begin
          bof <= mk_bof[top];
          sof <= mk_sof[top];
          sol <= t_sol;
          sp  <= sp - 1'b1;
          if (t_short) begin
            ndirty    <= '0;
            fill_left <= t_sol - ndirty[6:0];
          end else begin
            ndirty    <= ndirty - CW'(t_sol);
          end
        end else err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_call && push_ok) begin
      mk_bof[sp[TW-1:0]] <= bof;
      mk_sof[sp[TW-1:0]] <= sof;
      mk_sol[sp[TW-1:0]] <= sol;
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_port
    logic [VW-1:0] v, off;
    logic          stk;
    assign v   = vreg_i[k*VW +: VW];
    assign stk = v >= VW'(32);
    assign off = v - VW'(32);
    assign glob_o[k] = !stk;
    assign oof_o[k]  = stk && (off >= sof);
    assign phys_o[k*PW +: PW] = stk ? wrap({1'b0, bof} + (PW+1)'(off)) : PW'(v);
  end

  assign busy_o      = busy;
  assign err_o       = err;
  assign mem_valid_o = busy;
  assign mem_we_o    = spilling;
  assign mem_addr_o  = spilling ? bsp : bsp - 1'b1;
  assign mem_phys_o  = spilling ? wrap({1'b0, bof} + PHYS_W - ndirty)
                                : wrap({1'b0, bof} + (PW+1)'(fill_left) - 1'b1);

  a_r3_frame_limit: assert property (@(posedge clk) disable iff (!rst_n)
    sof <= 7'd96);
  a_r7_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (CW+1)'(ndirty) + (CW+1)'(sof) <= PHYS_C);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_phys_o)
      && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (call_i || alloc_i || ret_i) |=> $stable(sof) && $stable(bof) && $stable(sp));
  a_r4_call: assert property (@(posedge clk) disable iff (!rst_n)
    do_call && push_ok |=> sol == '0 && sof == $past(sof) - $past(sol));
  a_r6_depth: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= (TW+1)'(MDEPTH));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

// File: tb/sim_regstack_renamer.sv
module sim_regstack_renamer;
  localparam int CLK_PERIOD = 10;
  localparam int PHYS = 96;
  localparam int PW = 7;

  logic clk = 0, rst_n = 0;
  logic [20:0] vreg = '0;
  logic [3*PW-1:0] phys;
  logic [2:0] glob, oof;
  logic call_s = 0, alloc_s = 0, ret_s = 0, ready = 1;
  logic [6:0] l_s = 0, o_s = 0, r_s = 0;
  logic busy, err, mvalid, mwe;
  logic [15:0] maddr;
  logic [PW-1:0] mphys;

  always #(CLK_PERIOD/2) clk = ~clk;

  regstack_renamer #(.PHYS(PHYS)) u0 (
    .clk(clk), .rst_n(rst_n), .vreg_i(vreg), .phys_o(phys), .glob_o(glob), .oof_o(oof),
    .call_i(call_s), .alloc_i(alloc_s), .alloc_loc_i(l_s), .alloc_out_i(o_s),
    .alloc_rot_i(r_s), .ret_i(ret_s), .busy_o(busy), .err_o(err),
    .mem_valid_o(mvalid), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_phys_o(mphys),
    .mem_ready_i(ready));

  int nchk = 0, nfail = 0;
  int ntx = 0, fp, fa, lp, la, fwe;
  bit done = 0;

  always @(negedge clk) if (rst_n && mvalid && ready) begin
    if (ntx == 0) begin fp = mphys; fa = maddr; fwe = mwe; end
    lp = mphys; la = maddr; ntx++;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idx(int k);
    return int'(phys[k*PW +: PW]);
  endfunction

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; call_s = 0; alloc_s = 0; ret_s = 0; ready = 1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic strobe(int code, int l, int o, int r);
    @(posedge clk); #1;
    ntx = 0;
    l_s = 7'(l); o_s = 7'(o); r_s = 7'(r);
    call_s = (code == 2); alloc_s = (code == 1); ret_s = (code == 3);
    @(posedge clk); #1;
    call_s = 0; alloc_s = 0; ret_s = 0;
  endtask

  task automatic op(int code, int l, int o, int r);
    strobe(code, l, o, r);
    while (busy) begin @(posedge clk); #1; end
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] op; logic [6:0] l, o, va, ea, vb;
    logic [5:0] ntx; logic [6:0] fp, fa, lp, la; logic we;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'd1, 7'd14, 7'd6,  7'd51,  7'd19, 7'd52,  6'd0,  7'd0,  7'd0,  7'd0,  7'd0,  1'b0},
    '{2'd2, 7'd0,  7'd0,  7'd37,  7'd19, 7'd38,  6'd0,  7'd0,  7'd0,  7'd0,  7'd0,  1'b0},
    '{2'd1, 7'd20, 7'd4,  7'd55,  7'd37, 7'd56,  6'd0,  7'd0,  7'd0,  7'd0,  7'd0,  1'b0},
    '{2'd2, 7'd0,  7'd0,  7'd35,  7'd37, 7'd36,  6'd0,  7'd0,  7'd0,  7'd0,  7'd0,  1'b0},
    '{2'd1, 7'd80, 7'd10, 7'd121, 7'd27, 7'd122, 6'd28, 7'd0,  7'd0,  7'd27, 7'd27, 1'b1},
    '{2'd3, 7'd0,  7'd0,  7'd55,  7'd37, 7'd56,  6'd14, 7'd27, 7'd27, 7'd14, 7'd14, 1'b0},
    '{2'd3, 7'd0,  7'd0,  7'd51,  7'd19, 7'd52,  6'd14, 7'd13, 7'd13, 7'd0,  7'd0,  1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    vreg = {7'd5, 7'd5, 7'd32};
    @(negedge clk);
    chk("R2 reset busy", int'(busy), 0);
    chk("R10 reset err", int'(err), 0);
    chk("R7 reset mem_valid", int'(mvalid), 0);
    chk("R2 empty frame oof", int'(oof[0]), 1);
    chk("R1 global flag", int'(glob[1]), 1);
    chk("R1 global index", idx(1), 5);
    chk("R1 global oof", int'(oof[1]), 0);

    for (int i = 0; i < 7; i++) begin
      string tag;
      tag = (VEC[i].op == 1) ? "R3" : (VEC[i].op == 2) ? "R4" : "R5";
      vreg = {7'd7, VEC[i].vb, VEC[i].va};
      op(int'(VEC[i].op), int'(VEC[i].l), int'(VEC[i].o), 0);
      chk({tag, " R2 index"}, idx(0), int'(VEC[i].ea));
      chk({tag, " in frame"}, int'(oof[0]), 0);
      chk({tag, " past frame oof"}, int'(oof[1]), 1);
      chk("R1 port2 global", int'(glob[2]) * 100 + idx(2), 107);
      chk({tag, " err"}, int'(err), 0);
      chk(VEC[i].we ? "R7 spill count" : "R8 fill count", ntx, int'(VEC[i].ntx));
      if (VEC[i].ntx != 0) begin
        string tt;
        tt = VEC[i].we ? "R7" : "R8";
        chk({tt, " direction"}, fwe, int'(VEC[i].we));
        chk({tt, " first phys"}, fp, int'(VEC[i].fp));
        chk({tt, " first addr"}, fa, int'(VEC[i].fa));
        chk({tt, " last phys"}, lp, int'(VEC[i].lp));
        chk({tt, " last addr"}, la, int'(VEC[i].la));
      end
    end

    // R5: return on empty marker stack
    vreg = {7'd0, 7'd41, 7'd51};
    op(3, 0, 0, 0);
    chk("R5 empty return err", int'(err), 1);
    chk("R5 empty return frame kept", idx(0) * 2 + int'(oof[0]), 38);
    op(1, 10, 2, 0);
    chk("R10 err sticky", int'(err), 1);
    chk("R3 alloc after err", idx(1) * 2 + int'(oof[1]), 18);

    // R3: oversize and bad rotating count
    do_reset();
    vreg = {7'd0, 7'd0, 7'd32};
    op(1, 90, 10, 0);
    chk("R3 oversize err", int'(err), 1);
    chk("R3 oversize ignored", int'(oof[0]), 1);
    do_reset();
    op(1, 4, 0, 8);
    chk("R3 rotating err", int'(err), 1);
    chk("R3 rotating ignored", int'(oof[0]), 1);
    op(1, 0, 0, 0);
    do_reset();
    op(1, 6, 2, 8);
    chk("R3 rotating equal ok", int'(err) * 2 + int'(oof[0]), 0);

    // R6: marker stack depth
    do_reset();
    for (int i = 0; i < 16; i++) op(2, 0, 0, 0);
    chk("R6 16 calls ok", int'(err), 0);
    op(2, 0, 0, 0);
    chk("R6 17th call err", int'(err), 1);

    // R9: stall and ignored strobes while busy
    do_reset();
    vreg = {7'd0, 7'd0, 7'd121};
    op(1, 14, 6, 0);
    op(2, 0, 0, 0);
    @(posedge clk); #1 ready = 0;
    strobe(1, 80, 10, 0);
    @(negedge clk);
    chk("R9 busy", int'(busy), 1);
    chk("R7 spill valid", int'(mvalid) * 2 + int'(mwe), 3);
    chk("R7 spill first phys", int'(mphys), 0);
    chk("R7 spill first addr", int'(maddr), 0);
    strobe(2, 0, 0, 0);
    strobe(3, 0, 0, 0);
    @(negedge clk);
    chk("R9 stall hold", int'(mvalid) * 1000 + int'(mphys) * 10 + int'(maddr), 1000);
    @(posedge clk); #1 ready = 1;
    while (busy) begin @(posedge clk); #1; end
    @(negedge clk);
    chk("R7 spill total", ntx, 8);
    chk("R9 strobes ignored", idx(0) * 2 + int'(oof[0]), 14);
    chk("R9 no err", int'(err), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule